// File: doc/BRIEF.md
# Caller ID serial byte receiver

This block takes the demodulated caller ID bit stream, one serial line at 1200 bit/s, and works out what the line is carrying. An alternating 0/1 pattern marks channel seizure. A line held steadily high is a mark run. Framed characters carry the data. Each framed character is recovered as a parallel byte. The byte comes with a one-cycle valid strobe. A separate one-cycle flag reports a byte whose stop bit was bad.

The serial input is first resynchronised through two flops. The byte engine then waits for a falling edge on the line. It checks the start bit at its midpoint and takes eight data bits at bit centres, least significant first. It then checks the stop bit. After a good stop bit the engine re-arms on the next falling edge only.

A free-running bit-period window runs beside the byte engine and counts line transitions. From those counts it raises a seizure flag and a mark flag. Both the byte engine and the window run whenever the enable is high. When the enable is low, both are held in their rest state. The consumer drops any bytes it does not expect.

Top module: `cid_byte_rx`

## Requirements
- R1: Bit values are sampled at bit centres. The first bit after the start bit is byte_o[0] and the eighth is byte_o[7]. byte_o holds the byte while byte_valid_o is high and keeps it until the next good byte.
- R2: byte_valid_o is high for exactly one clock per received byte.
- R3: A stop bit that is low at its centre gives a one-cycle frame_err_o pulse and no byte_valid_o for that byte.
- R4: After a framing error, no new start bit is searched for until the line has returned high. A line held low afterwards yields no further byte or error.
- R5: A start bit that is high again at its centre, half a bit time after the falling edge, is rejected without a byte or an error.
- R6: seizure_o is 1 once at least RUN_LEN consecutive bit-period windows each held exactly one transition. It returns to 0 at the first window that does not.
- R7: mark_o is 1 once at least RUN_LEN consecutive bit-period windows had no transition and a high line. It returns to 0 at the first window that breaks this.
- R8: While en_i is 0, no byte_valid_o or frame_err_o is produced and seizure_o and mark_o are 0.
- R9: After a good stop bit, the falling edge that begins the next start bit re-arms the bit timer. Bytes sent back to back with a single stop bit are all received.
- R10: After reset, byte_o, byte_valid_o, frame_err_o, seizure_o and mark_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Receiver enable |
| rxd_i | input | 1 | Demodulated serial data, idle high |
| byte_o | output | 8 | Last good received byte |
| byte_valid_o | output | 1 | One-cycle strobe for a new byte |
| frame_err_o | output | 1 | One-cycle strobe for a low stop bit |
| seizure_o | output | 1 | Alternating seizure pattern detected |
| mark_o | output | 1 | Steady mark run detected |

## Verification
Two things can land on the same clock: the stop-bit decision of the byte engine and the closing of a line-class window. This happens because both count bit periods from unrelated origins. The full sweep of all 256 byte values varies the idle gap after each byte over every window phase, so each byte is decided at a different offset inside the window. Each byte must still come out exact with a single strobe. The flags must follow the line pattern, which shows that neither path disturbs the other when they coincide.

// File: rtl/cid_rx_pkg.sv
package cid_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_WAIT_HI
  } rx_state_e;
endpackage

// File: rtl/cid_in_sync.sv
module cid_in_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic fall_o,
  output logic edge_o
);
  logic [2:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= 3'b111;
    else         q <= {q[1:0], d_i};
  end

  assign lvl_o  = q[1];
  assign fall_o = q[2] & ~q[1];
  assign edge_o = q[2] ^ q[1];
endmodule

// File: rtl/cid_line_class.sv
module cid_line_class #(
  parameter int BIT_CLKS = 10000,
  parameter int RUN_LEN  = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic lvl_i,
  input  logic edge_i,
  output logic seizure_o,
  output logic mark_o
);
  localparam int CW = $clog2(BIT_CLKS);
  localparam int RW = $clog2(RUN_LEN + 1);

  logic [CW-1:0] per_cnt;
  logic [1:0]    edge_cnt;
  logic [1:0]    win_edges;
  logic [RW-1:0] seiz_run, mark_run;
  logic          win_end;

  assign win_end   = (per_cnt == CW'(BIT_CLKS - 1));
  assign win_edges = (edge_cnt == 2'd2) ? 2'd2 : edge_cnt + {1'b0, edge_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_cnt  <= '0;
      edge_cnt <= '0;
      seiz_run <= '0;
      mark_run <= '0;
    end else if (!en_i) begin
      per_cnt  <= '0;
      edge_cnt <= '0;
      seiz_run <= '0;
      mark_run <= '0;
    end else if (win_end) begin
      per_cnt  <= '0;
      edge_cnt <= '0;
      if (win_edges == 2'd1)
        seiz_run <= (seiz_run == RW'(RUN_LEN)) ? seiz_run : seiz_run + 1'b1;
      else
        seiz_run <= '0;
      if (win_edges == 2'd0 && lvl_i)
        mark_run <= (mark_run == RW'(RUN_LEN)) ? mark_run : mark_run + 1'b1;
      else
        mark_run <= '0;
    end else begin
      per_cnt  <= per_cnt + 1'b1;
      edge_cnt <= win_edges;
    end
  end

  assign seizure_o = (seiz_run == RW'(RUN_LEN));
  assign mark_o    = (mark_run == RW'(RUN_LEN));

  // R6
  seiz_mark_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(seizure_o && mark_o));
  // R7
  mark_rise_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mark_o) |-> $past(lvl_i));
  // R8
  flags_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !seizure_o && !mark_o);
endmodule

// File: rtl/cid_byte_fsm.sv
module cid_byte_fsm
  import cid_rx_pkg::*;
#(
  parameter int BIT_CLKS = 10000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       lvl_i,
  input  logic       fall_i,
  output logic [7:0] byte_o,
  output logic       valid_o,
  output logic       ferr_o
);
  localparam int HALF = BIT_CLKS / 2;
  localparam int CW   = $clog2(BIT_CLKS);

  rx_state_e     state;
  logic [CW-1:0] cnt;
  logic [2:0]    bit_idx;
  logic [7:0]    shreg;
  logic          half_hit, full_hit;

  assign half_hit = (cnt == CW'(HALF - 1));
  assign full_hit = (cnt == CW'(BIT_CLKS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= RX_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
      shreg   <= '0;
      byte_o  <= '0;
      valid_o <= 1'b0;
      ferr_o  <= 1'b0;
    end else if (!en_i) begin
      state   <= RX_IDLE;
      cnt     <= '0;
      valid_o <= 1'b0;
      ferr_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      ferr_o  <= 1'b0;
      case (state)
        RX_IDLE: begin
          cnt <= '0;
          if (fall_i) state <= RX_START;
        end
        RX_START: begin
          if (half_hit) begin
            cnt     <= '0;
            bit_idx <= '0;
            state   <= lvl_i ? RX_IDLE : RX_DATA;  // glitch reject
          end else cnt <= cnt + 1'b1;
        end
        RX_DATA: begin
          if (full_hit) begin
            cnt   <= '0;
            shreg <= {lvl_i, shreg[7:1]};
            if (bit_idx == 3'd7) state <= RX_STOP;
            else bit_idx <= bit_idx + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        RX_STOP: begin
          if (full_hit) begin
            cnt <= '0;
            if (lvl_i) begin
              byte_o  <= shreg;
              valid_o <= 1'b1;
              state   <= RX_IDLE;
            end else begin
              ferr_o <= 1'b1;
              state  <= RX_WAIT_HI;
            end
          end else cnt <= cnt + 1'b1;
        end
        RX_WAIT_HI: if (lvl_i) state <= RX_IDLE;
        default: state <= RX_IDLE;
      endcase
    end
  end

  // R2
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R3
  valid_ferr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && ferr_o));
  // R4
  wait_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == RX_WAIT_HI && !lvl_i && en_i) |=> state == RX_WAIT_HI);
  // R8
  strobes_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !valid_o && !ferr_o);
  // R9
  rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == RX_IDLE && fall_i && en_i) |=> state == RX_START);
endmodule

// File: rtl/cid_byte_rx.sv
module cid_byte_rx #(
  parameter int CLKS_PER_BIT = 10000,
  parameter int RUN_LEN      = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       rxd_i,
  output logic [7:0] byte_o,
  output logic       byte_valid_o,
  output logic       frame_err_o,
  output logic       seizure_o,
  output logic       mark_o
);
  logic lvl, fall, edg;

  cid_in_sync u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .lvl_o (lvl),
    .fall_o(fall),
    .edge_o(edg)
  );

  cid_byte_fsm #(.BIT_CLKS(CLKS_PER_BIT)) u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .lvl_i  (lvl),
    .fall_i (fall),
    .byte_o (byte_o),
    .valid_o(byte_valid_o),
    .ferr_o (frame_err_o)
  );

  cid_line_class #(.BIT_CLKS(CLKS_PER_BIT), .RUN_LEN(RUN_LEN)) u_class (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .lvl_i    (lvl),
    .edge_i   (edg),
    .seizure_o(seizure_o),
    .mark_o   (mark_o)
  );
endmodule

// File: tb/tb_cid_byte_rx.sv
module tb_cid_byte_rx;
  localparam int BITC = 16;
  localparam int RUN  = 10;

  logic       clk = 1'b0, rst_ni = 1'b0, en_i = 1'b0, rxd_i = 1'b1;
  logic [7:0] byte_o;
  logic       byte_valid_o, frame_err_o, seizure_o, mark_o;

  cid_byte_rx #(.CLKS_PER_BIT(BITC), .RUN_LEN(RUN)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .rxd_i(rxd_i),
    .byte_o(byte_o), .byte_valid_o(byte_valid_o), .frame_err_o(frame_err_o),
    .seizure_o(seizure_o), .mark_o(mark_o)
  );

  always #5 clk = ~clk;

  int n_tests = 0, n_fail = 0, vcnt = 0, fcnt = 0, wide = 0;
  int v0, f0;
  logic [7:0] last_b = '0;
  logic pv = 1'b0;

  always @(negedge clk) begin
    if (byte_valid_o) begin
      vcnt++;
      last_b = byte_o;
      if (pv) wide++;
    end
    pv = byte_valid_o;
    if (frame_err_o) fcnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hold(input bit v, input int nbits);
    rxd_i = v;
    repeat (nbits * BITC) @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] b, input bit stopv);
    hold(1'b0, 1);
    for (int i = 0; i < 8; i++) hold(b[i], 1);
    hold(stopv, 1);
  endtask

  task automatic toggle(input int nbits);
    for (int i = 0; i < nbits; i++) hold(i[0] ? 1'b1 : 1'b0, 1);
  endtask

  initial begin
    #1_900_000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R10
    chk({byte_o, byte_valid_o, frame_err_o, seizure_o, mark_o} == '0, "R10 reset outputs",
        int'({byte_o, byte_valid_o, frame_err_o, seizure_o, mark_o}), 0);
    en_i = 1'b1;
    hold(1'b1, 14);
    // R7
    chk(mark_o == 1'b1, "R7 mark after idle high", int'(mark_o), 1);

    // R1 full sweep, idle gap varied over every window phase
    for (int b = 0; b < 256; b++) begin
      v0 = vcnt;
      frame(b[7:0], 1'b1);
      chk(vcnt == v0 + 1 && last_b == b[7:0], "R1 byte sweep", int'(last_b), b);
      rxd_i = 1'b1;
      repeat (b % BITC) @(negedge clk);
    end
    // R2
    chk(wide == 0, "R2 strobe width", wide, 0);

    // R9 back to back with one stop bit
    v0 = vcnt;
    frame(8'h12, 1'b1);
    frame(8'h34, 1'b1);
    chk(vcnt == v0 + 2, "R9 back-to-back count", vcnt - v0, 2);
    chk(last_b == 8'h34, "R9 second byte", int'(last_b), 'h34);
    hold(1'b1, 2);

    // R3 / R4 low stop then line stays low
    v0 = vcnt; f0 = fcnt;
    frame(8'h3C, 1'b0);
    hold(1'b0, 20);
    chk(fcnt == f0 + 1, "R3 framing error", fcnt - f0, 1);
    chk(vcnt == v0, "R3 no byte on bad stop", vcnt - v0, 0);
    chk(fcnt == f0 + 1 && vcnt == v0, "R4 no restart while low", fcnt - f0 + vcnt - v0, 1);
    hold(1'b1, 2);
    frame(8'hA5, 1'b1);
    chk(vcnt == v0 + 1 && last_b == 8'hA5, "R4 recovery byte", int'(last_b), 'hA5);

    // R5 short low glitch
    hold(1'b1, 2);
    v0 = vcnt; f0 = fcnt;
    rxd_i = 1'b0;
    repeat (3) @(negedge clk);
    hold(1'b1, 12);
    chk(vcnt == v0 && fcnt == f0, "R5 glitch rejected", vcnt - v0 + fcnt - f0, 0);

    // R6 / R7 line classification
    toggle(6);
    chk(seizure_o == 1'b0, "R6 short seizure run", int'(seizure_o), 0);
    chk(mark_o == 1'b0, "R7 mark cleared by toggling", int'(mark_o), 0);
    toggle(14);
    chk(seizure_o == 1'b1, "R6 seizure detected", int'(seizure_o), 1);
    hold(1'b1, 6);
    chk(seizure_o == 1'b0, "R6 seizure cleared", int'(seizure_o), 0);
    chk(mark_o == 1'b0, "R7 short mark run", int'(mark_o), 0);
    hold(1'b1, 8);
    chk(mark_o == 1'b1, "R7 mark detected", int'(mark_o), 1);

    // R8 disabled receiver
    en_i = 1'b0;
    v0 = vcnt; f0 = fcnt;
    frame(8'h77, 1'b1);
    toggle(20);
    chk(seizure_o == 1'b0, "R8 no seizure when disabled", int'(seizure_o), 0);
    frame(8'h3C, 1'b0);
    hold(1'b1, 14);
    chk(vcnt == v0 && fcnt == f0, "R8 no strobes when disabled", vcnt - v0 + fcnt - f0, 0);
    chk(mark_o == 1'b0, "R8 no mark when disabled", int'(mark_o), 0);
    en_i = 1'b1;
    hold(1'b1, 2);
    frame(8'h5A, 1'b1);
    chk(vcnt == v0 + 1 && last_b == 8'h5A, "R8 byte after enable", int'(last_b), 'h5A);
    hold(1'b1, 2);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule